// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block keeps a 63-bit cycle count and compares it with a programmable limit. When the count reaches the limit, it sends a one-cycle set pulse to one bit of an external soft-interrupt register. That bit then stays set until software clears it. The count advances by one on each cycle in which the tick enable is high. A write to the count port overrides the increment in that cycle.

Bit 63 of each 64-bit register image is a control flag and is stored apart from the 63-bit value:

- On the count register it is a read-protection flag. A count read returns the flag in bit 63.
- On the limit register it is an interrupt-disable flag.

A limit value of zero leaves the compare unarmed. The same design is placed three times: one processor tick timer and two system tick timers. The `KIND` parameter chooses which soft-interrupt bit the instance drives. Privilege checks and scaling of the count rate are done outside this block.

Top module: `tick_compare_unit`

## Requirements
- R1: After reset, the count reads 0 with the protection flag clear. The limit reads 64'h8000_0000_0000_0000 (disable set, compare value zero). `softint_set` is all zeros.
- R2: With `tick_en` high and no count write, the count rises by exactly one per clock. With `tick_en` low and no write, the count holds.
- R3: An increment from 63'h7FFF_FFFF_FFFF_FFFF gives 0. The protection flag is not changed by the wrap.
- R4: On a count write, bits 62:0 of `cnt_wdata` load the counter and bit 63 loads the protection flag. A write takes priority over an increment in the same cycle.
- R5: `cnt_rdata` bits 62:0 are the current count, and bit 63 is 1 exactly when the protection flag is set.
- R6: On a limit write, bit 63 of `lim_wdata` becomes the disable flag and bits 62:0 become the compare value. `lim_rdata` returns both in the same positions.
- R7: When the counter takes a value equal to a nonzero, enabled compare value, `softint_set` pulses for one cycle. This applies whether the counter got there by increment or by write. The pulse appears in the cycle that follows that clock edge.
- R8: A compare value of zero never produces a pulse, even when the count is zero.
- R9: While the disable flag is set there is no pulse. A limit write that sets the disable flag on the same edge at which the count reaches the limit cancels that pending pulse.
- R10: `softint_set` is 17 bits wide. The tick kind pulses bit 0. Both system kinds pulse bit 16. All other bits are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the count this cycle |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 64 | Count write image: bit 63 is the protection flag |
| cnt_rdata | output | 64 | Count read image |
| lim_wr | input | 1 | Write strobe for the limit register |
| lim_wdata | input | 64 | Limit write image: bit 63 is the disable flag |
| lim_rdata | output | 64 | Limit read image |
| softint_set | output | 17 | One-cycle set pulse toward the soft-interrupt register |

## Verification
The assertions assume that the inputs are known values at every sampled clock edge. They also assume that writes can come at any time, including on the same edge as the match. The bench drives every input only just after a falling edge, so each value is stable at the next rising edge. The bench places limit and count writes on deliberate edges to create the match, cancel and same-edge-write cases. A second instance with a system kind shares all inputs, so its pulse bit can be checked against the tick instance.

// File: rtl/tick_pkg.sv
package tick_pkg;

   // Which timer flavour an instance represents
   typedef enum logic [1:0] {
      TK_TICK = 2'd0,
      TK_SYS  = 2'd1,
      TK_HYP  = 2'd2
   } tick_kind_e;

   // Soft-interrupt register layout decoded by the neighbour
   localparam int SOFT_W     = 17;
   localparam int TM_BIT_POS = 0;
   localparam int SM_BIT_POS = 16;

   function automatic int kind_bit(input tick_kind_e k);
      return (k == TK_TICK) ? TM_BIT_POS : SM_BIT_POS;
   endfunction

endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ld_flag,
   output logic [CNT_W-1:0] cnt_q,
   output logic             flag_q,
   output logic             moved_q
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (ld)       cnt_d = ld_val;
      else if (adv) cnt_d = cnt_q + ONE;
      else          cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flag_q  <= 1'b0;
         moved_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         moved_q <= ld | adv;
         if (ld) flag_q <= ld_flag;
      end
   end

endmodule

// File: rtl/tick_limit_reg.sv
module tick_limit_reg #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             wr_dis,
   output logic [CNT_W-1:0] lim_q,
   output logic             dis_q,
   output logic             armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         dis_q <= 1'b1;
      end else if (wr) begin
         lim_q <= wr_val;
         dis_q <= wr_dis;
      end
   end

   assign armed = (|lim_q) & ~dis_q;

endmodule

// File: rtl/tick_match_det.sv
module tick_match_det #(
   parameter int CNT_W   = 63,
   parameter int SOFT_W  = 17,
   parameter int HIT_BIT = 0
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  lim,
   input  logic              armed,
   input  logic              moved,
   output logic [SOFT_W-1:0] set_vec
);

   logic hit;

   assign hit = armed & moved & (cnt == lim);

   for (genvar i = 0; i < SOFT_W; i++) begin : g_bit
      if (i == HIT_BIT) begin : g_hit
         assign set_vec[i] = hit;
      end else begin : g_zero
         assign set_vec[i] = 1'b0;
      end
   end

endmodule

// File: rtl/tick_compare_unit.sv
module tick_compare_unit #(
   parameter int                   CNT_W = 63,
   parameter tick_pkg::tick_kind_e KIND  = tick_pkg::TK_TICK
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_en,
   input  logic                        cnt_wr,
   input  logic [CNT_W:0]              cnt_wdata,
   output logic [CNT_W:0]              cnt_rdata,
   input  logic                        lim_wr,
   input  logic [CNT_W:0]              lim_wdata,
   output logic [CNT_W:0]              lim_rdata,
   output logic [tick_pkg::SOFT_W-1:0] softint_set
);

   localparam int FLAG_POS  = CNT_W;
   localparam int MATCH_BIT = tick_pkg::kind_bit(KIND);

   if (CNT_W < 2) begin : g_bad_width
      $error("tick_compare_unit: CNT_W must be at least 2");
   end
   if (MATCH_BIT >= tick_pkg::SOFT_W) begin : g_bad_bit
      $error("tick_compare_unit: match bit outside soft-interrupt register");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             prot_q;
   logic             moved_q;
   logic [CNT_W-1:0] lim_q;
   logic             dis_q;
   logic             armed;

   tick_count_reg #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (tick_en),
      .ld      (cnt_wr),
      .ld_val  (cnt_wdata[CNT_W-1:0]),
      .ld_flag (cnt_wdata[FLAG_POS]),
      .cnt_q   (cnt_q),
      .flag_q  (prot_q),
      .moved_q (moved_q)
   );

   tick_limit_reg #(.CNT_W(CNT_W)) u_limit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (lim_wr),
      .wr_val (lim_wdata[CNT_W-1:0]),
      .wr_dis (lim_wdata[FLAG_POS]),
      .lim_q  (lim_q),
      .dis_q  (dis_q),
      .armed  (armed)
   );

   tick_match_det #(
      .CNT_W   (CNT_W),
      .SOFT_W  (tick_pkg::SOFT_W),
      .HIT_BIT (MATCH_BIT)
   ) u_match (
      .cnt     (cnt_q),
      .lim     (lim_q),
      .armed   (armed),
      .moved   (moved_q),
      .set_vec (softint_set)
   );

   assign cnt_rdata = {prot_q, cnt_q};
   assign lim_rdata = {dis_q, lim_q};

endmodule

// File: rtl/tick_compare_unit_chk.sv
module tick_compare_unit_chk #(
   parameter int CNT_W = 63
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick_en,
   input logic                        cnt_wr,
   input logic [CNT_W:0]              cnt_wdata,
   input logic [CNT_W:0]              cnt_rdata,
   input logic                        lim_wr,
   input logic [CNT_W:0]              lim_wdata,
   input logic [CNT_W:0]              lim_rdata,
   input logic [tick_pkg::SOFT_W-1:0] softint_set
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   AST_SET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(softint_set));                                                   // R10
   AST_INCR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr) |=> cnt_rdata[CNT_W-1:0] == $past(cnt_rdata[CNT_W-1:0]) + ONE); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr) |=> $stable(cnt_rdata));                            // R2
   AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_rdata == $past(cnt_wdata));                                // R4
   AST_LIM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lim_wr |=> lim_rdata == $past(lim_wdata));                                // R6
   AST_SET_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (|softint_set) |-> cnt_rdata[CNT_W-1:0] == lim_rdata[CNT_W-1:0]);         // R7
   AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|softint_set) && !cnt_wr) |=> softint_set == '0);                       // R7
   AST_NO_SET_ZERO_LIM: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_rdata[CNT_W-1:0] == '0) |-> softint_set == '0);                      // R8
   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      lim_rdata[CNT_W] |-> softint_set == '0);                                  // R9

endmodule

bind tick_compare_unit tick_compare_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .cnt_wr      (cnt_wr),
   .cnt_wdata   (cnt_wdata),
   .cnt_rdata   (cnt_rdata),
   .lim_wr      (lim_wr),
   .lim_wdata   (lim_wdata),
   .lim_rdata   (lim_rdata),
   .softint_set (softint_set)
);

// File: tb/tick_compare_unit_bench.sv
module tick_compare_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [62:0] CMAX = 63'h7FFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [63:0] cnt_wdata = '0;
   logic        lim_wr = 1'b0;
   logic [63:0] lim_wdata = '0;
   logic [63:0] cnt_rdata, lim_rdata, cnt_rdata_s, lim_rdata_s;
   logic [16:0] softint_set, softint_set_s;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_compare_unit u_tick_compare_unit (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .lim_wr(lim_wr),
      .lim_wdata(lim_wdata), .lim_rdata(lim_rdata), .softint_set(softint_set));

   tick_compare_unit #(.KIND(tick_pkg::TK_HYP)) u_tick_compare_unit_sys (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata_s), .lim_wr(lim_wr),
      .lim_wdata(lim_wdata), .lim_rdata(lim_rdata_s), .softint_set(softint_set_s));

   // Reference model built from the requirements
   logic [62:0] m_cnt, m_lim;
   logic        m_npt, m_dis, m_moved;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_npt <= 1'b0; m_lim <= '0; m_dis <= 1'b1; m_moved <= 1'b0;
      end else begin
         if (cnt_wr) begin m_cnt <= cnt_wdata[62:0]; m_npt <= cnt_wdata[63]; end
         else if (tick_en) m_cnt <= m_cnt + 63'd1;
         m_moved <= cnt_wr | tick_en;
         if (lim_wr) begin m_lim <= lim_wdata[62:0]; m_dis <= lim_wdata[63]; end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_model(input string req);
      logic [16:0] es;
      es = (m_moved && !m_dis && m_lim != 0 && m_cnt == m_lim) ? 17'h00001 : 17'h0;
      chk(cnt_rdata == {m_npt, m_cnt}, {req, " count"}, cnt_rdata, {m_npt, m_cnt});
      chk(lim_rdata == {m_dis, m_lim}, {req, " limit"}, lim_rdata, {m_dis, m_lim});
      chk(softint_set == es, {req, " set"}, 64'(softint_set), 64'(es));
      chk(softint_set_s == {es[0], 16'h0}, {req, " sys set"}, 64'(softint_set_s), 64'({es[0], 16'h0}));
   endtask

   // advance one clock and sample at the falling edge, inputs dropped after
   task automatic step(input string req);
      @(posedge clk); @(negedge clk);
      cnt_wr = 1'b0; lim_wr = 1'b0;
      chk_model(req);
   endtask

   task automatic wr_cnt(input logic [63:0] v);
      cnt_wr = 1'b1; cnt_wdata = v;
   endtask

   task automatic wr_lim(input logic [63:0] v);
      lim_wr = 1'b1; lim_wdata = v;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(cnt_rdata == 64'h0, "R1 count", cnt_rdata, 64'h0);
      chk(lim_rdata == 64'h8000_0000_0000_0000, "R1 limit", lim_rdata, 64'h8000_0000_0000_0000);
      chk(softint_set == 17'h0, "R1 set", 64'(softint_set), 64'h0);
   endtask

   task automatic t_count;
      tick_en = 1'b1;
      for (int i = 0; i < 5; i++) step("R2 incr");
      chk(cnt_rdata == 64'd5, "R2 five ticks", cnt_rdata, 64'd5);
      tick_en = 1'b0;
      for (int i = 0; i < 3; i++) step("R2 hold");
      chk(cnt_rdata == 64'd5, "R2 held", cnt_rdata, 64'd5);
   endtask

   task automatic t_write;
      tick_en = 1'b1;
      wr_cnt(64'h8000_0000_0000_1000);
      step("R4 write over tick");
      chk(cnt_rdata == 64'h8000_0000_0000_1000, "R4 R5 write wins", cnt_rdata, 64'h8000_0000_0000_1000);
      step("R5 flag on read");
      chk(cnt_rdata == 64'h8000_0000_0000_1001, "R5 flag kept", cnt_rdata, 64'h8000_0000_0000_1001);
      wr_cnt(64'h0000_0000_0000_0042);
      step("R5 flag cleared");
      chk(cnt_rdata == 64'h42, "R5 flag clear", cnt_rdata, 64'h42);
      tick_en = 1'b0;
   endtask

   task automatic t_wrap;
      wr_cnt({1'b1, CMAX - 63'd1});
      step("R3 load");
      tick_en = 1'b1;
      step("R3 max");
      chk(cnt_rdata == {1'b1, CMAX}, "R3 at max", cnt_rdata, {1'b1, CMAX});
      step("R3 wrap");
      chk(cnt_rdata == 64'h8000_0000_0000_0000, "R3 wrapped", cnt_rdata, 64'h8000_0000_0000_0000);
      tick_en = 1'b0;
   endtask

   task automatic t_limit_rw;
      wr_lim(64'hC123_4567_89AB_CDEF);
      step("R6 limit write");
      chk(lim_rdata == 64'hC123_4567_89AB_CDEF, "R6 readback", lim_rdata, 64'hC123_4567_89AB_CDEF);
   endtask

   task automatic t_match;
      wr_cnt(64'd100); wr_lim(64'd103);
      step("R7 setup");
      tick_en = 1'b1;
      step("R7 101"); step("R7 102"); step("R7 103");
      chk(softint_set == 17'h00001, "R7 R10 tick bit0", 64'(softint_set), 64'h1);
      chk(softint_set_s == 17'h10000, "R10 system bit16", 64'(softint_set_s), 64'h10000);
      step("R7 after");
      chk(softint_set == 17'h0, "R7 one cycle", 64'(softint_set), 64'h0);
      tick_en = 1'b0;
      step("R7 idle");
      wr_cnt(64'd103);
      step("R7 by write");
      chk(softint_set == 17'h00001, "R7 write hit", 64'(softint_set), 64'h1);
      step("R7 stopped");
      chk(softint_set == 17'h0, "R7 stopped no repeat", 64'(softint_set), 64'h0);
   endtask

   task automatic t_zero;
      wr_lim(64'h0); wr_cnt({1'b0, CMAX});
      step("R8 setup");
      tick_en = 1'b1;
      step("R8 reach zero");
      chk(cnt_rdata == 64'h0, "R8 count zero", cnt_rdata, 64'h0);
      chk(softint_set == 17'h0, "R8 no set", 64'(softint_set), 64'h0);
      tick_en = 1'b0;
   endtask

   task automatic t_disable;
      wr_lim(64'h8000_0000_0000_00C8); wr_cnt(64'd198);
      step("R9 setup");
      tick_en = 1'b1;
      step("R9 199"); step("R9 200");
      chk(softint_set == 17'h0, "R9 disabled", 64'(softint_set), 64'h0);
      wr_lim(64'd300); wr_cnt(64'd298);
      step("R9 rearm"); step("R9 299");
      wr_lim(64'h8000_0000_0000_012C);
      step("R9 cancel same edge");
      chk(cnt_rdata == 64'd300, "R9 reached", cnt_rdata, 64'd300);
      chk(softint_set == 17'h0, "R9 cancelled", 64'(softint_set), 64'h0);
      tick_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_write();
      t_wrap();
      t_limit_rw();
      t_match();
      t_zero();
      t_disable();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule